// File: doc/BRIEF.md
# Serial Register Port for a Dual-Channel Gain Stage

This block is the control-side serial slave of a two-channel variable-gain amplifier. A host talks to it over a four-wire serial link: a bit clock, an active-low frame select, a data input and a data output that is released whenever the slave is not answering. Each frame is 32 bits long. A valid frame carries a data word, a register number and a device identifier. The frame is stored when the select line returns high. The registers it writes drive the channel enables, the bias and impedance settings and the gain code that the gain-allocation logic downstream consumes.

Reads go through register 0. A write to register 0 stores a pointer. During the very next frame, the slave shifts out the addressed register, followed by that register's number and the device identifier. The data carried in on that same frame is still written when the frame ends. Two consecutive writes to register 0, first 0x20 and then 0x00, put every register back to its power-up value.

The serial pins are oversampled in the system clock domain. They pass through a short synchronizer and an edge detector. The output pin is presented as a data bit plus an output-enable, ready for a pad driver.

Top module: `spi_gain_regs`

## Requirements
- R1: A frame is the bits sampled on rising bit-clock edges while the frame select is low, taken MSB first. The first 24 bits are data, the next 5 bits are the register number, and the last 3 bits are the device identifier. A frame is stored only when the select line rises, and registers change at no other time.
- R2: Only frames whose identifier equals 3'b110 are stored. A frame with any other identifier changes no register and does not disturb the reset sequence of R11.
- R3: A frame with fewer or more than 32 rising edges is discarded. The next fall of the select line restarts the bit count.
- R4: After reset, the registers hold these values. Register 1 holds bit0 = I-channel enable = 1 and bit1 = Q-channel enable = 1. Register 2 holds bits[1:0] amplifier bias = 01, bits[3:2] driver bias = 01, bit4 impedance select = 1, and bits 5, 6, 7 (gain source, decoder off, deglitch off) = 0. Register 3 holds bits[8:0] gain code = 0. Register 0 holds 0.
- R5: Register fields reach the outputs directly: the register 1 bits on the enable outputs, the register 2 bits on the bias and mode outputs, and register 3 bits[8:0] on the gain code. Data bits above these fields are dropped.
- R6: A stored write to register 0 keeps data bits[5:0]. Bits[4:0] are the read pointer. The write arms a readback for the next frame only.
- R7: During an armed frame, the output-enable is high and the output shifts {24-bit register data, 5-bit pointer, 3'b110} MSB first. Each new bit appears after a rising bit-clock edge.
- R8: Register bits that are not stored, and every register number other than 0 to 3, read back as zero.
- R9: Outside an armed frame the output-enable is low. It drops after every frame.
- R10: Data received during a readback frame is stored like any other frame.
- R11: A stored write of 0x000020 to register 0, followed directly by a stored write of 0x000000 to register 0, returns every register to its R4 value. Any other stored frame in between cancels the sequence.
- R12: The synchronous active-high reset input forces the R4 values and a low output-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on reset) |
| spi_sck | input | 1 | Serial bit clock |
| spi_sen_n | input | 1 | Frame select, active low |
| spi_sdi | input | 1 | Serial data in |
| spi_sdo | output | 1 | Serial data out |
| spi_sdo_oe | output | 1 | Output enable for the data-out pad |
| ch_i_en | output | 1 | I-channel enable |
| ch_q_en | output | 1 | Q-channel enable |
| amp_bias | output | 2 | Amplifier bias code |
| drv_bias | output | 2 | Output driver bias code |
| zin_high | output | 1 | High input-impedance select |
| gain_src_spi | output | 1 | Gain taken from the register instead of pins |
| decode_off | output | 1 | Gain decode bypass |
| deglitch_off | output | 1 | Gain deglitch bypass |
| gain_code | output | 9 | Register gain code |

## Verification
The assertions assume that the serial pins are slow against the system clock, so that each bit-clock phase spans several clock cycles. They also assume that the bit clock does not toggle in the cycles where the select line moves, so that every edge is seen once after synchronization. The stimulus holds each bit-clock phase for eight system clocks. It changes data only while the bit clock is low, and it leaves several idle cycles around each select transition. Under those conditions, registers change only on stored frames, and the output-enable rises only when a readback was armed.

// File: rtl/spi_gain_pkg.sv
package spi_gain_pkg;
  localparam int DATA_W  = 24;
  localparam int ADDR_W  = 5;
  localparam int CHIP_W  = 3;
  localparam int FRAME_W = DATA_W + ADDR_W + CHIP_W;
  localparam int PTR_W   = 6;
  localparam int EN_W    = 2;
  localparam int CFG_W   = 8;
  localparam int GAIN_W  = 9;

  localparam logic [CHIP_W-1:0] CHIP_ID  = 3'b110;
  localparam logic [EN_W-1:0]   EN_DEF   = 2'b11;
  localparam logic [CFG_W-1:0]  CFG_DEF  = 8'h15;
  localparam logic [GAIN_W-1:0] GAIN_DEF = '0;
  localparam logic [DATA_W-1:0] SRST_KEY = 24'h000020;

  typedef enum logic [ADDR_W-1:0] {
    REG_PTR  = 5'd0,
    REG_EN   = 5'd1,
    REG_CFG  = 5'd2,
    REG_GAIN = 5'd3
  } reg_sel_e;
endpackage

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_gain_pkg::*;
#(
  parameter int DATA_BITS   = DATA_W,
  parameter int ADDR_BITS   = ADDR_W,
  parameter int CHIP_BITS   = CHIP_W,
  parameter int SYNC_STAGES = 2,
  parameter logic [CHIP_BITS-1:0] CHIP_MATCH = CHIP_ID
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sck,
  input  logic                 sen_n,
  input  logic                 sdi,
  output logic                 frame_start,
  output logic                 bit_stb,
  output logic                 frame_end,
  output logic                 wr_stb,
  output logic [DATA_BITS-1:0] wr_data,
  output logic [ADDR_BITS-1:0] wr_addr
);
  localparam int LEN   = DATA_BITS + ADDR_BITS + CHIP_BITS;
  localparam int CNT_W = $clog2(LEN + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(LEN);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(LEN + 1);

  logic [SYNC_STAGES:0]   sck_p, sen_p;
  logic [SYNC_STAGES-1:0] sdi_p;
  logic [CNT_W-1:0]       cnt;
  logic [LEN-1:0]         shreg;
  logic sck_s, sck_d, sen_s, sen_d, sdi_s;
  logic sen_fall, sen_rise, sck_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p <= '0;
      sen_p <= '1;
      sdi_p <= '0;
    end else begin
      sck_p <= {sck_p[SYNC_STAGES-1:0], sck};
      sen_p <= {sen_p[SYNC_STAGES-1:0], sen_n};
      sdi_p <= {sdi_p[SYNC_STAGES-2:0], sdi};
    end
  end

  assign sck_s = sck_p[SYNC_STAGES-1];
  assign sck_d = sck_p[SYNC_STAGES];
  assign sen_s = sen_p[SYNC_STAGES-1];
  assign sen_d = sen_p[SYNC_STAGES];
  assign sdi_s = sdi_p[SYNC_STAGES-1];

  always_comb begin
    sen_fall = sen_d & ~sen_s;
    sen_rise = ~sen_d & sen_s;
    sck_rise = sck_s & ~sck_d & ~sen_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (sen_fall) begin
      cnt <= '0;
    end else if (sck_rise) begin
      shreg <= {shreg[LEN-2:0], sdi_s};
      if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_start <= 1'b0;
      bit_stb     <= 1'b0;
      frame_end   <= 1'b0;
      wr_stb      <= 1'b0;
      wr_data     <= '0;
      wr_addr     <= '0;
    end else begin
      frame_start <= sen_fall;
      bit_stb     <= sck_rise;
      frame_end   <= sen_rise;
      wr_stb      <= sen_rise && (cnt == CNT_FULL) &&
                     (shreg[CHIP_BITS-1:0] == CHIP_MATCH);
      if (sen_rise) begin
        wr_data <= shreg[LEN-1 -: DATA_BITS];
        wr_addr <= shreg[CHIP_BITS +: ADDR_BITS];
      end
    end
  end

  // R3: the bit count only moves while a frame is open
  p_cnt_idle_r3: assert property (@(posedge clk) disable iff (rst)
    sen_s |=> $stable(cnt));
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_gain_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              frame_end,
  output logic              rb_armed,
  output logic [FRAME_W-1:0] rd_word,
  output logic [EN_W-1:0]   en_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [GAIN_W-1:0] gain_o
);
  logic [PTR_W-1:0]  ptr_q;
  logic [EN_W-1:0]   en_q;
  logic [CFG_W-1:0]  cfg_q;
  logic [GAIN_W-1:0] gain_q;
  logic              srst_arm_q;
  logic              rb_armed_q;
  logic              to_ptr, srst_fire;
  logic [DATA_W-1:0] rd_data;

  always_comb begin
    to_ptr    = wr_stb && (wr_addr == REG_PTR);
    srst_fire = to_ptr && (wr_data == '0) && srst_arm_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q      <= '0;
      en_q       <= EN_DEF;
      cfg_q      <= CFG_DEF;
      gain_q     <= GAIN_DEF;
      srst_arm_q <= 1'b0;
    end else if (wr_stb) begin
      srst_arm_q <= to_ptr && (wr_data == SRST_KEY);
      if (srst_fire) begin
        ptr_q  <= '0;
        en_q   <= EN_DEF;
        cfg_q  <= CFG_DEF;
        gain_q <= GAIN_DEF;
      end else begin
        case (wr_addr)
          REG_PTR:  ptr_q  <= wr_data[PTR_W-1:0];
          REG_EN:   en_q   <= wr_data[EN_W-1:0];
          REG_CFG:  cfg_q  <= wr_data[CFG_W-1:0];
          REG_GAIN: gain_q <= wr_data[GAIN_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             rb_armed_q <= 1'b0;
    else if (to_ptr)     rb_armed_q <= 1'b1;
    else if (frame_end)  rb_armed_q <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    case (ptr_q[ADDR_W-1:0])
      REG_PTR:  rd_data[PTR_W-1:0]  = ptr_q;
      REG_EN:   rd_data[EN_W-1:0]   = en_q;
      REG_CFG:  rd_data[CFG_W-1:0]  = cfg_q;
      REG_GAIN: rd_data[GAIN_W-1:0] = gain_q;
      default:  rd_data = '0;
    endcase
    rd_word = {rd_data, ptr_q[ADDR_W-1:0], CHIP_ID};
  end

  assign rb_armed = rb_armed_q;
  assign en_o     = en_q;
  assign cfg_o    = cfg_q;
  assign gain_o   = gain_q;

  // R11: the second key write leaves every register at its default
  p_srst_defaults_r11: assert property (@(posedge clk) disable iff (rst)
    srst_fire |=> (en_q == EN_DEF && cfg_q == CFG_DEF &&
                   gain_q == GAIN_DEF && ptr_q == '0));

  // R1: registers move only on a stored frame
  p_regs_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> ($stable(en_q) && $stable(cfg_q) &&
                 $stable(gain_q) && $stable(ptr_q)));
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              bit_stb,
  input  logic              frame_end,
  input  logic              rb_armed,
  input  logic [WORD_W-1:0] rd_word,
  output logic              sdo,
  output logic              sdo_oe
);
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else if (frame_end) begin
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else if (frame_start) begin
      sdo_oe <= rb_armed;
      sdo    <= 1'b0;
      sh_q   <= rd_word;
    end else if (bit_stb && sdo_oe) begin
      sdo  <= sh_q[WORD_W-1];
      sh_q <= {sh_q[WORD_W-2:0], 1'b0};
    end
  end

  // R9: the pad is released once a frame closes
  p_hiz_after_frame_r9: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> !sdo_oe);

  // R6: driving starts only for a frame armed by a pointer write
  p_oe_needs_arm_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_oe) |-> $past(rb_armed));
endmodule

// File: rtl/spi_gain_regs.sv
module spi_gain_regs
  import spi_gain_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_sen_n,
  input  logic              spi_sdi,
  output logic              spi_sdo,
  output logic              spi_sdo_oe,
  output logic              ch_i_en,
  output logic              ch_q_en,
  output logic [1:0]        amp_bias,
  output logic [1:0]        drv_bias,
  output logic              zin_high,
  output logic              gain_src_spi,
  output logic              decode_off,
  output logic              deglitch_off,
  output logic [GAIN_W-1:0] gain_code
);
  logic frame_start, bit_stb, frame_end, wr_stb, rb_armed;
  logic [DATA_W-1:0]  wr_data;
  logic [ADDR_W-1:0]  wr_addr;
  logic [FRAME_W-1:0] rd_word;
  logic [EN_W-1:0]    en_w;
  logic [CFG_W-1:0]   cfg_w;

  spi_frame_rx #(
    .DATA_BITS(DATA_W), .ADDR_BITS(ADDR_W), .CHIP_BITS(CHIP_W),
    .SYNC_STAGES(SYNC_STAGES), .CHIP_MATCH(CHIP_ID)
  ) u_rx (
    .clk(clk), .rst(rst), .sck(spi_sck), .sen_n(spi_sen_n), .sdi(spi_sdi),
    .frame_start(frame_start), .bit_stb(bit_stb), .frame_end(frame_end),
    .wr_stb(wr_stb), .wr_data(wr_data), .wr_addr(wr_addr)
  );

  spi_reg_bank u_bank (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
    .wr_addr(wr_addr), .frame_end(frame_end), .rb_armed(rb_armed),
    .rd_word(rd_word), .en_o(en_w), .cfg_o(cfg_w), .gain_o(gain_code)
  );

  spi_tx_shift #(.WORD_W(FRAME_W)) u_tx (
    .clk(clk), .rst(rst), .frame_start(frame_start), .bit_stb(bit_stb),
    .frame_end(frame_end), .rb_armed(rb_armed), .rd_word(rd_word),
    .sdo(spi_sdo), .sdo_oe(spi_sdo_oe)
  );

  assign ch_i_en      = en_w[0];
  assign ch_q_en      = en_w[1];
  assign amp_bias     = cfg_w[1:0];
  assign drv_bias     = cfg_w[3:2];
  assign zin_high     = cfg_w[4];
  assign gain_src_spi = cfg_w[5];
  assign decode_off   = cfg_w[6];
  assign deglitch_off = cfg_w[7];
endmodule

// File: tb/sim_spi_gain_regs.sv
module sim_spi_gain_regs;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sck = 1'b0, spi_sen_n = 1'b1, spi_sdi = 1'b0;
  logic spi_sdo, spi_sdo_oe, ch_i_en, ch_q_en, zin_high;
  logic gain_src_spi, decode_off, deglitch_off;
  logic [1:0] amp_bias, drv_bias;
  logic [8:0] gain_code;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  typedef struct {
    string       req;
    bit          drive;
    logic [31:0] exp;
  } exp_t;
  exp_t exp_q[$];

  logic [31:0] cap_word;
  bit cap_any, cap_all, oe_after;
  event frame_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_gain_regs u0 (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_sen_n(spi_sen_n),
    .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
    .ch_i_en(ch_i_en), .ch_q_en(ch_q_en), .amp_bias(amp_bias),
    .drv_bias(drv_bias), .zin_high(zin_high), .gain_src_spi(gain_src_spi),
    .decode_off(decode_off), .deglitch_off(deglitch_off),
    .gain_code(gain_code)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] fw(input logic [23:0] d,
                                     input logic [4:0] a,
                                     input logic [2:0] c);
    return {d, a, c};
  endfunction

  // driver: pushes the expected readback, then plays the frame
  task automatic run_frame(input logic [31:0] word, input int nbits,
                           input string req, input bit drive,
                           input logic [31:0] exp);
    exp_t it;
    it.req = req; it.drive = drive; it.exp = exp;
    exp_q.push_back(it);
    cap_word = '0; cap_any = 1'b0; cap_all = 1'b1;
    spi_sen_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      spi_sdi = (i < 32) ? word[31-i] : 1'b0;
      wait_clk(HALF);
      spi_sck = 1'b1;
      wait_clk(HALF);
      cap_word = {cap_word[30:0], spi_sdo};
      cap_all  = cap_all & spi_sdo_oe;
      cap_any  = cap_any | spi_sdo_oe;
      spi_sck = 1'b0;
    end
    wait_clk(HALF);
    spi_sen_n = 1'b1;
    wait_clk(8);
    oe_after = spi_sdo_oe;
    ->frame_done;
    wait_clk(2);
  endtask

  // monitor: pops the expected item for each finished frame
  initial begin
    exp_t it;
    forever begin
      @(frame_done);
      if (exp_q.size() == 0) begin
        check("R7 scoreboard empty", 32'd1, 32'd0);
      end else begin
        it = exp_q.pop_front();
        if (it.drive) begin
          check({it.req, " readback word"}, cap_word, it.exp);
          check({it.req, " oe through frame"}, {31'd0, cap_all}, 32'd1);
        end else begin
          check({it.req, " R9 pad released"}, {31'd0, cap_any}, 32'd0);
        end
        check("R9 oe low after frame", {31'd0, oe_after}, 32'd0);
      end
    end
  end

  task automatic check_regs(input string req, input logic [1:0] en,
                            input logic [7:0] cfg, input logic [8:0] gain);
    check({req, " enables"}, {30'd0, ch_q_en, ch_i_en}, {30'd0, en});
    check({req, " settings"}, {24'd0, deglitch_off, decode_off, gain_src_spi,
          zin_high, drv_bias, amp_bias}, {24'd0, cfg});
    check({req, " gain"}, {23'd0, gain_code}, {23'd0, gain});
  endtask

  task automatic wr(input logic [23:0] d, input logic [4:0] a,
                    input string req, input bit drive,
                    input logic [31:0] exp);
    run_frame(fw(d, a, 3'b110), 32, req, drive, exp);
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);
    check_regs("R4 reset defaults", 2'b11, 8'h15, 9'h000);
    check("R9 oe idle after reset", {31'd0, spi_sdo_oe}, 32'd0);

    wr(24'hABCFA5, 5'd3, "R5 gain write", 1'b0, 32'd0);
    wr(24'h0000E6, 5'd2, "R5 settings write", 1'b0, 32'd0);
    wr(24'h000002, 5'd1, "R5 enable write", 1'b0, 32'd0);
    check_regs("R5 R1 fields", 2'b10, 8'hE6, 9'h1A5);

    run_frame(fw(24'h7, 5'd3, 3'b101), 32, "R2 foreign id", 1'b0, 32'd0);
    check_regs("R2 foreign id ignored", 2'b10, 8'hE6, 9'h1A5);
    run_frame(fw(24'h7, 5'd3, 3'b110), 20, "R3 short frame", 1'b0, 32'd0);
    check_regs("R3 short frame dropped", 2'b10, 8'hE6, 9'h1A5);
    run_frame(fw(24'h7, 5'd3, 3'b110), 33, "R3 long frame", 1'b0, 32'd0);
    check_regs("R3 long frame dropped", 2'b10, 8'hE6, 9'h1A5);

    wr(24'h000003, 5'd0, "R6 pointer to 3", 1'b0, 32'd0);
    wr(24'h000003, 5'd1, "R7 read gain", 1'b1, fw(24'h1A5, 5'd3, 3'b110));
    check_regs("R10 readback frame stored", 2'b11, 8'hE6, 9'h1A5);

    wr(24'h000002, 5'd0, "R6 pointer to 2", 1'b0, 32'd0);
    run_frame(fw(24'h7, 5'd3, 3'b101), 32, "R7 read settings",
              1'b1, fw(24'hE6, 5'd2, 3'b110));
    check_regs("R2 foreign readback frame ignored", 2'b11, 8'hE6, 9'h1A5);

    wr(24'h00000A, 5'd0, "R6 pointer to 10", 1'b0, 32'd0);
    wr(24'h000001, 5'd0, "R8 read unused reg", 1'b1, fw(24'h0, 5'd10, 3'b110));
    wr(24'h000055, 5'd3, "R7 read enables", 1'b1, fw(24'h3, 5'd1, 3'b110));
    wr(24'h000001, 5'd1, "R6 arm only one frame", 1'b0, 32'd0);

    wr(24'h000020, 5'd0, "R11 key write", 1'b0, 32'd0);
    wr(24'h0000AA, 5'd3, "R11 read reg0", 1'b1, fw(24'h20, 5'd0, 3'b110));
    wr(24'h000000, 5'd0, "R11 broken sequence", 1'b0, 32'd0);
    check_regs("R11 no reset after break", 2'b01, 8'hE6, 9'h0AA);

    wr(24'h000020, 5'd0, "R11 key write 2", 1'b1, fw(24'h0, 5'd0, 3'b110));
    run_frame(fw(24'h0, 5'd0, 3'b011), 32, "R2 foreign between keys",
              1'b1, fw(24'h20, 5'd0, 3'b110));
    wr(24'h000000, 5'd0, "R11 second key", 1'b0, 32'd0);
    check_regs("R11 soft reset", 2'b11, 8'h15, 9'h000);
    wr(24'h0000FF, 5'd2, "R11 reg0 cleared", 1'b1, fw(24'h0, 5'd0, 3'b110));

    run_frame(fw(24'h3, 5'd0, 3'b110), 16, "R3 short pointer write",
              1'b0, 32'd0);
    wr(24'h000000, 5'd1, "R3 short write did not arm", 1'b0, 32'd0);
    check_regs("R3 R10 state", 2'b00, 8'hFF, 9'h000);

    wr(24'hFFFFFF, 5'd2, "R5 settings all ones", 1'b0, 32'd0);
    wr(24'h000002, 5'd0, "R6 pointer to 2 again", 1'b0, 32'd0);
    wr(24'hFFFFFF, 5'd3, "R8 unused bits zero", 1'b1, fw(24'hFF, 5'd2, 3'b110));
    wr(24'h000003, 5'd0, "R6 pointer to 3 again", 1'b0, 32'd0);
    wr(24'h000003, 5'd1, "R8 gain width", 1'b1, fw(24'h1FF, 5'd3, 3'b110));
    check_regs("R5 wide gain", 2'b11, 8'hFF, 9'h1FF);

    rst = 1'b1;
    wait_clk(2);
    rst = 1'b0;
    wait_clk(2);
    check_regs("R12 reset input", 2'b11, 8'h15, 9'h000);
    check("R12 oe low", {31'd0, spi_sdo_oe}, 32'd0);

    wait_clk(4);
    check("R7 scoreboard drained", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule